// File: doc/BRIEF.md
# Priority Interrupt Level Encoder

This block collects the interrupt sources of a processor board and turns them into one 4-bit priority level for the CPU. Some sources are plain levels. They show up while their line is high and drop out when it falls: the two programmed interrupt bits, the hard disk line, the floppy line and the UART line. Two sources are sticky. A rising edge on the interval timer output, or a DMA end-of-process edge that belongs to a UART transfer, sets a pending latch. That latch stays set until software pulses its clear strobe.

When several sources are active, the highest level wins. The all-ones code means that nothing is pending. A separate valid output tells a real level-15 timer request apart from that idle code. The block compares the pending level with the processor's current mask level and raises a request only when the mask is strictly lower. Two status flags go back to software. One shows that the DMA latch is set. The other shows that the floppy raised its line, so software can tell the two level-11 sources apart.

Top module: `irq_level_encoder`

## Requirements
- R1: After reset, `ipl` is 15 and `iplValid`, `irqReq`, `dmaFlag` and `diskFlag` are all 0.
- R2: `progIrq8` and `progIrq9` produce levels 8 and 9. The level is present one clock after the bit is sampled high and gone one clock after it is sampled low.
- R3: `hardDiskIrq` and `floppyIrq` each produce level 11, and only while the line is sampled high.
- R4: `uartIrq` produces level 13 while it is sampled high. It has no latch.
- R5: A rising edge of `dmaEop` sampled together with `dmaUartRx` or `dmaUartTx` high sets a level-13 pending latch, shown on `dmaFlag`. The latch holds until `clrDma` is sampled high. An edge with both qualifiers low has no effect.
- R6: A rising edge of `timerOut` sets a level-15 pending latch, which holds until `clrTimer` is sampled high. A line that stays high after the clear does not set the latch again.
- R7: With several sources active, `ipl` shows the highest of their levels (timer 15 > DMA/UART 13 > disk 11 > 9 > 8).
- R8: With no source active, `ipl` is 15 and `iplValid` is 0. Any active source, the timer included, gives `iplValid` = 1.
- R9: `irqReq` is 1 exactly when a level is valid and `cpuMask` (sampled on the same edge) is strictly less than it. A mask of 15 therefore blocks every request.
- R10: `floppyIrq` sampled high sets `diskFlag` until `clrDisk` is sampled high. `hardDiskIrq` never sets it.
- R11: When a set and its clear fall on the same edge, the set wins and the latch stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progIrq8 | input | 1 | Programmed interrupt bit, level 8 |
| progIrq9 | input | 1 | Programmed interrupt bit, level 9 |
| hardDiskIrq | input | 1 | Hard disk controller interrupt line |
| floppyIrq | input | 1 | Floppy controller interrupt line |
| uartIrq | input | 1 | Combined UART interrupt line |
| dmaEop | input | 1 | DMA end-of-process, active high |
| dmaUartRx | input | 1 | Current DMA transfer is a UART receive |
| dmaUartTx | input | 1 | Current DMA transfer is a UART transmit |
| timerOut | input | 1 | Interval timer output |
| clrTimer | input | 1 | Software clear of the timer latch |
| clrDma | input | 1 | Software clear of the DMA latch |
| clrDisk | input | 1 | Software clear of the disk status flag |
| cpuMask | input | 4 | Processor's current interrupt mask level |
| ipl | output | 4 | Highest pending level, 15 when idle |
| iplValid | output | 1 | A source is pending |
| irqReq | output | 1 | Pending level exceeds the mask |
| dmaFlag | output | 1 | DMA completion latch state |
| diskFlag | output | 1 | Floppy interrupt status flag |

## Verification
A level input sampled at one edge appears on `ipl`, `iplValid` and `irqReq` right after that edge. `cpuMask` is registered on that same edge. A timer or DMA edge sampled at edge k sets its latch, and `dmaFlag` shows it, right after k. The latch reaches `ipl` only after edge k+1. A clear strobe follows the same two-edge path. The bench drives inputs shortly after each rising edge and keeps a behavioural model that advances on the same edges. It compares every output at the falling edge that follows, so each result is sampled in the cycle it is due.

// File: rtl/iple_pkg.sv
package iple_pkg;

  // Strobes from the control module to the datapath latches.
  typedef struct packed {
    logic timerSet;
    logic timerClr;
    logic dmaSet;
    logic dmaClr;
    logic diskSet;
    logic diskClr;
  } iple_strobe_t;

  localparam int unsigned EDGE_TIMER = 0;
  localparam int unsigned EDGE_EOP   = 1;
  localparam int unsigned NUM_EDGE   = 2;

endpackage

// File: rtl/iple_ctrl.sv
module iple_ctrl
  import iple_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         timerOut,
  input  logic         dmaEop,
  input  logic         dmaUartRx,
  input  logic         dmaUartTx,
  input  logic         floppyIrq,
  input  logic         clrTimer,
  input  logic         clrDma,
  input  logic         clrDisk,
  output iple_strobe_t strobes
);

  logic [NUM_EDGE-1:0] edgeIn;
  logic [NUM_EDGE-1:0] edgePrev;
  logic [NUM_EDGE-1:0] edgeRise;

  assign edgeIn[EDGE_TIMER] = timerOut;
  assign edgeIn[EDGE_EOP]   = dmaEop;

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgePrev[g] <= 1'b0;
      else       edgePrev[g] <= edgeIn[g];
    end
    assign edgeRise[g] = edgeIn[g] & ~edgePrev[g];
  end

  logic uartXfer;
  assign uartXfer = dmaUartRx | dmaUartTx;

  always_comb begin
    strobes          = '0;
    strobes.timerSet = edgeRise[EDGE_TIMER];
    strobes.timerClr = clrTimer;
    strobes.dmaSet   = edgeRise[EDGE_EOP] & uartXfer;
    strobes.dmaClr   = clrDma;
    strobes.diskSet  = floppyIrq;
    strobes.diskClr  = clrDisk;
  end

  // R6: one timer edge yields a single-cycle set strobe
  a_r6_single_timer_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.timerSet |=> !strobes.timerSet);

  // R5: one end-of-process edge yields a single-cycle set strobe
  a_r5_single_dma_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dmaSet |=> !strobes.dmaSet);

endmodule

// File: rtl/iple_datapath.sv
module iple_datapath
  import iple_pkg::*;
#(
  parameter int unsigned LVL_W      = 4,
  parameter int unsigned LVL_PROG8  = 8,
  parameter int unsigned LVL_PROG9  = 9,
  parameter int unsigned LVL_DISK   = 11,
  parameter int unsigned LVL_UART   = 13,
  parameter int unsigned LVL_TIMER  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  iple_strobe_t     strobes,
  input  logic             progIrq8,
  input  logic             progIrq9,
  input  logic             hardDiskIrq,
  input  logic             floppyIrq,
  input  logic             uartIrq,
  input  logic [LVL_W-1:0] cpuMask,
  output logic [LVL_W-1:0] ipl,
  output logic             iplValid,
  output logic             irqReq,
  output logic             dmaFlag,
  output logic             diskFlag
);

  localparam int unsigned NSRC = 7;
  localparam logic [LVL_W-1:0] IDLE_LVL = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] SRC_LEVEL [NSRC] = '{
    LVL_W'(LVL_PROG8), LVL_W'(LVL_PROG9), LVL_W'(LVL_DISK), LVL_W'(LVL_DISK),
    LVL_W'(LVL_UART),  LVL_W'(LVL_UART),  LVL_W'(LVL_TIMER)
  };

  logic timerPend;
  logic dmaPend;
  logic diskPend;

  // Sticky latches: a set on the same edge as a clear wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerPend <= 1'b0;
      dmaPend   <= 1'b0;
      diskPend  <= 1'b0;
    end else begin
      if (strobes.timerSet)      timerPend <= 1'b1;
      else if (strobes.timerClr) timerPend <= 1'b0;
      if (strobes.dmaSet)        dmaPend   <= 1'b1;
      else if (strobes.dmaClr)   dmaPend   <= 1'b0;
      if (strobes.diskSet)       diskPend  <= 1'b1;
      else if (strobes.diskClr)  diskPend  <= 1'b0;
    end
  end

  assign dmaFlag  = dmaPend;
  assign diskFlag = diskPend;

  logic [NSRC-1:0] srcActive;
  assign srcActive = {timerPend, dmaPend, uartIrq, floppyIrq,
                      hardDiskIrq, progIrq9, progIrq8};

  logic [LVL_W-1:0] bestLvl;
  logic             anyAct;

  always_comb begin
    bestLvl = '0;
    anyAct  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (srcActive[i] && (!anyAct || SRC_LEVEL[i] > bestLvl)) begin
        bestLvl = SRC_LEVEL[i];
        anyAct  = 1'b1;
      end
    end
  end

  logic [LVL_W-1:0] nextIpl;
  assign nextIpl = anyAct ? bestLvl : IDLE_LVL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipl      <= IDLE_LVL;
      iplValid <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      ipl      <= nextIpl;
      iplValid <= anyAct;
      irqReq   <= anyAct && (cpuMask < nextIpl);
    end
  end

  // R6: the timer latch holds until a clear strobe
  a_r6_timer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (timerPend && !strobes.timerClr) |=> timerPend);

  // R7: a pending timer dominates the output level on the next edge
  a_r7_timer_wins: assert property (@(posedge clk) disable iff (!rstN)
    timerPend |=> (ipl == IDLE_LVL && iplValid));

  // R5: the DMA latch only rises after a qualified set strobe
  a_r5_dma_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaPend) |-> $past(strobes.dmaSet));

  // R10: the disk flag only rises after the floppy line was high
  a_r10_disk_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(diskFlag) |-> $past(floppyIrq));

  // R9: a full mask blocks every request
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMask == IDLE_LVL) |=> !irqReq);

  // R8: without a valid level the idle code is shown and nothing is requested
  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    !iplValid |-> (ipl == IDLE_LVL && !irqReq));

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import iple_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progIrq8,
  input  logic             progIrq9,
  input  logic             hardDiskIrq,
  input  logic             floppyIrq,
  input  logic             uartIrq,
  input  logic             dmaEop,
  input  logic             dmaUartRx,
  input  logic             dmaUartTx,
  input  logic             timerOut,
  input  logic             clrTimer,
  input  logic             clrDma,
  input  logic             clrDisk,
  input  logic [LVL_W-1:0] cpuMask,
  output logic [LVL_W-1:0] ipl,
  output logic             iplValid,
  output logic             irqReq,
  output logic             dmaFlag,
  output logic             diskFlag
);

  iple_strobe_t strobes;

  iple_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .timerOut  (timerOut),
    .dmaEop    (dmaEop),
    .dmaUartRx (dmaUartRx),
    .dmaUartTx (dmaUartTx),
    .floppyIrq (floppyIrq),
    .clrTimer  (clrTimer),
    .clrDma    (clrDma),
    .clrDisk   (clrDisk),
    .strobes   (strobes)
  );

  iple_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .progIrq8    (progIrq8),
    .progIrq9    (progIrq9),
    .hardDiskIrq (hardDiskIrq),
    .floppyIrq   (floppyIrq),
    .uartIrq     (uartIrq),
    .cpuMask     (cpuMask),
    .ipl         (ipl),
    .iplValid    (iplValid),
    .irqReq      (irqReq),
    .dmaFlag     (dmaFlag),
    .diskFlag    (diskFlag)
  );

endmodule

// File: tb/irq_level_encoder_tb.sv
module irq_level_encoder_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progIrq8 = 0, progIrq9 = 0, hardDiskIrq = 0, floppyIrq = 0, uartIrq = 0;
  logic dmaEop = 0, dmaUartRx = 0, dmaUartTx = 0, timerOut = 0;
  logic clrTimer = 0, clrDma = 0, clrDisk = 0;
  logic [3:0] cpuMask = 4'd15;
  logic [3:0] ipl;
  logic iplValid, irqReq, dmaFlag, diskFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  irq_level_encoder u_dut (
    .clk(clk), .rstN(rstN), .progIrq8(progIrq8), .progIrq9(progIrq9),
    .hardDiskIrq(hardDiskIrq), .floppyIrq(floppyIrq), .uartIrq(uartIrq),
    .dmaEop(dmaEop), .dmaUartRx(dmaUartRx), .dmaUartTx(dmaUartTx),
    .timerOut(timerOut), .clrTimer(clrTimer), .clrDma(clrDma), .clrDisk(clrDisk),
    .cpuMask(cpuMask), .ipl(ipl), .iplValid(iplValid), .irqReq(irqReq),
    .dmaFlag(dmaFlag), .diskFlag(diskFlag)
  );

  // Behavioural reference model
  bit mTimerLast, mEopLast, mTimerPend, mDmaPend, mDiskPend;
  int mIpl = 15;
  bit mValid, mReq;

  function automatic int pickLevel(bit tp, bit dp, bit u, bit hd, bit fl, bit p9, bit p8);
    if (tp) return 15;
    if (dp || u) return 13;
    if (hd || fl) return 11;
    if (p9) return 9;
    if (p8) return 8;
    return 15;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTimerLast = 0; mEopLast = 0; mTimerPend = 0; mDmaPend = 0; mDiskPend = 0;
      mIpl = 15; mValid = 0; mReq = 0;
    end else begin
      bit any;
      any = mTimerPend | mDmaPend | uartIrq | hardDiskIrq | floppyIrq | progIrq9 | progIrq8;
      mIpl = pickLevel(mTimerPend, mDmaPend, uartIrq, hardDiskIrq, floppyIrq, progIrq9, progIrq8);
      mValid = any;
      mReq = any && (int'(cpuMask) < mIpl);
      if (timerOut && !mTimerLast) mTimerPend = 1; else if (clrTimer) mTimerPend = 0;
      if (dmaEop && !mEopLast && (dmaUartRx || dmaUartTx)) mDmaPend = 1;
      else if (clrDma) mDmaPend = 0;
      if (floppyIrq) mDiskPend = 1; else if (clrDisk) mDiskPend = 0;
      mTimerLast = timerOut;
      mEopLast = dmaEop;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("ipl", int'(ipl), mIpl);
    chk("iplValid", int'(iplValid), int'(mValid));
    chk("irqReq", int'(irqReq), int'(mReq));
    chk("dmaFlag", int'(dmaFlag), int'(mDmaPend));
    chk("diskFlag", int'(diskFlag), int'(mDiskPend));
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic explicitCheck(string req, int actIpl, int expIpl);
    string save;
    save = curReq;
    curReq = req;
    chk("directed ipl", actIpl, expIpl);
    curReq = save;
  endtask

  initial begin
    // R1: reset values
    curReq = "R1";
    step(3);
    chk("reset ipl", int'(ipl), 15);
    chk("reset valid", int'(iplValid), 0);
    rstN = 1'b1;
    step(2);

    curReq = "R2";
    cpuMask = 4'd7;
    progIrq8 = 1; step(2);
    explicitCheck("R2", int'(ipl), 8);
    progIrq9 = 1; step(2);
    explicitCheck("R2", int'(ipl), 9);
    progIrq9 = 0; progIrq8 = 0; step(2);

    curReq = "R3";
    hardDiskIrq = 1; step(2);
    explicitCheck("R3", int'(ipl), 11);
    hardDiskIrq = 0; step(1);
    floppyIrq = 1; step(1);
    floppyIrq = 0; step(2);

    curReq = "R10";
    explicitCheck("R10", int'(diskFlag), 1);
    clrDisk = 1; step(1); clrDisk = 0;
    hardDiskIrq = 1; step(2);
    explicitCheck("R10", int'(diskFlag), 0);
    hardDiskIrq = 0; step(2);

    curReq = "R4";
    uartIrq = 1; step(2);
    explicitCheck("R4", int'(ipl), 13);
    uartIrq = 0; step(2);

    curReq = "R5";
    dmaEop = 1; step(1); dmaEop = 0; step(2);
    explicitCheck("R5", int'(dmaFlag), 0);
    dmaUartRx = 1; dmaEop = 1; step(1); dmaEop = 0; dmaUartRx = 0; step(3);
    explicitCheck("R5", int'(ipl), 13);
    clrDma = 1; step(1); clrDma = 0; step(2);
    dmaUartTx = 1; dmaEop = 1; step(4); dmaEop = 0; dmaUartTx = 0; step(2);
    clrDma = 1; step(1); clrDma = 0; step(2);

    curReq = "R6";
    timerOut = 1; step(3);
    explicitCheck("R6", int'(iplValid), 1);
    clrTimer = 1; step(1); clrTimer = 0; step(3);
    explicitCheck("R6", int'(iplValid), 0);
    timerOut = 0; step(2);

    curReq = "R7";
    progIrq8 = 1; hardDiskIrq = 1; uartIrq = 1; step(2);
    explicitCheck("R7", int'(ipl), 13);
    timerOut = 1; step(3);
    explicitCheck("R7", int'(ipl), 15);
    timerOut = 0; clrTimer = 1; step(1); clrTimer = 0;
    uartIrq = 0; step(2);
    hardDiskIrq = 0; step(2);
    progIrq8 = 0; step(2);

    curReq = "R8";
    explicitCheck("R8", int'(ipl), 15);
    chk("idle valid", int'(iplValid), 0);

    curReq = "R9";
    for (int m = 0; m < 16; m++) begin
      cpuMask = 4'(m);
      hardDiskIrq = (m % 3) == 0;
      progIrq9 = (m % 2) == 0;
      step(1);
    end
    cpuMask = 4'd15; uartIrq = 1; step(2);
    chk("mask15 req", int'(irqReq), 0);
    cpuMask = 4'd12; step(1);
    chk("mask12 req", int'(irqReq), 1);
    cpuMask = 4'd13; step(1);
    chk("mask13 req", int'(irqReq), 0);
    uartIrq = 0; hardDiskIrq = 0; progIrq9 = 0; step(2);

    curReq = "R11";
    timerOut = 1; step(1); timerOut = 0; step(1);
    timerOut = 1; clrTimer = 1; step(1); clrTimer = 0; timerOut = 0; step(2);
    explicitCheck("R11", int'(ipl), 15);
    chk("set wins valid", int'(iplValid), 1);
    dmaUartRx = 1; dmaEop = 1; step(1); dmaEop = 0; step(1);
    dmaEop = 1; clrDma = 1; step(1); dmaEop = 0; clrDma = 0; dmaUartRx = 0; step(1);
    chk("dma set wins", int'(dmaFlag), 1);
    floppyIrq = 1; clrDisk = 1; step(1); floppyIrq = 0; clrDisk = 0; step(1);
    chk("disk set wins", int'(diskFlag), 1);
    clrTimer = 1; clrDma = 1; clrDisk = 1; step(1);
    clrTimer = 0; clrDma = 0; clrDisk = 0; step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule